// File: doc/BRIEF.md
# ADC Threshold and Status Flag Unit

This block sits beside the computation path of an analog-to-digital converter and condenses its results into one 8-bit status word. Each time the path signals a fresh result, the block takes the signed error word and compares it against two programmable limits, one above and one below. The outcome of each comparison is registered and held until the next fresh result.

Two events are remembered until software acknowledges them: an arithmetic overflow reported by the accumulator or the error calculation, and the fact that a new result has been produced. Software reads the word directly. It clears either remembered event by writing a mask in which that event's bit is 1. The current stage code of the conversion sequencer is carried in the low three bits of the same word, so a single read gives the full picture.

Top module: `adc_thr_status`

## Requirements
- R1: While reset is applied, and after it is released until the first event, every bit of `status_o` reads 0.
- R2: Bit 6 of `status_o` becomes 1 in the cycle after an update strobe exactly when the error is strictly greater than the upper limit. It becomes 0 otherwise, including when the two values are equal.
- R3: Bit 5 of `status_o` becomes 1 in the cycle after an update strobe exactly when the error is strictly less than the lower limit. It becomes 0 otherwise, including when the two values are equal.
- R4: Bits 6 and 5 keep their value in every cycle without an update strobe, even when the error or either limit changes.
- R5: Bit 7 becomes 1 in the cycle after `ovf_i` is high. It then stays 1 until a clear write with mask bit 7 set.
- R6: Bit 4 becomes 1 in the cycle after an update strobe. It then stays 1 until a clear write with mask bit 4 set.
- R7: When a set condition and a clear write hit bit 7 or bit 4 in the same cycle, the bit is 1 afterwards.
- R8: Bits 2:0 show the value that `stage_i` had one cycle earlier. Bit 3 always reads 0.
- R9: In a clear write, mask bits other than 7 and 4 have no effect. Clearing one of the two remembered bits leaves the other one unchanged.
- R10: Error and limits are compared as signed two's-complement numbers of width `W` (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| upd_i | input | 1 | Result-update strobe from the computation path |
| err_i | input | W | Signed error word |
| ovf_i | input | 1 | Overflow from the accumulator or the error calculation |
| hi_thr_i | input | W | Signed upper limit |
| lo_thr_i | input | W | Signed lower limit |
| stage_i | input | 3 | Sequencer stage code |
| clr_we_i | input | 1 | Clear-write strobe |
| clr_mask_i | input | 8 | Write-one-to-clear mask, aligned to the status bits |
| status_o | output | 8 | Status word |

## Verification
The assertions assume that update, overflow and clear-write strobes are sampled only after the internal reset has been released. They also assume that the inputs are stable around each rising edge, so that the value seen one cycle earlier is the value the registers captured. The bench changes every input on the falling edge and keeps all strobes low while reset is synchronized. It then drives each strobe for exactly one cycle, which keeps the one-cycle relations between inputs and status bits well defined.

// File: rtl/adc_thr_pkg.sv
package adc_thr_pkg;
  localparam int STAT_W  = 8;
  localparam int STAGE_W = 3;
  localparam int POS_OVF   = 7;
  localparam int POS_ABOVE = 6;
  localparam int POS_BELOW = 5;
  localparam int POS_UPD   = 4;
  localparam int N_STICKY  = 2;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/adc_thr_rst_sync.sv
module adc_thr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/adc_thr_cmp.sv
module adc_thr_cmp #(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] err_i,
  input  logic signed [W-1:0] hi_i,
  input  logic signed [W-1:0] lo_i,
  output logic                above_o,
  output logic                below_o
);
  logic above_d, below_d;

  always_comb begin
    above_d = above_o;
    below_d = below_o;
    if (en_i) begin
      above_d = (err_i > hi_i);
      below_d = (err_i < lo_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      above_o <= 1'b0;
      below_o <= 1'b0;
    end else begin
      above_o <= above_d;
      below_o <= below_d;
    end
  end
endmodule

// File: rtl/adc_thr_sticky.sv
module adc_thr_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  always_comb begin
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
    else            q_d = q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/adc_thr_status.sv
module adc_thr_status
  import adc_thr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                upd_i,
  input  logic signed [W-1:0] err_i,
  input  logic                ovf_i,
  input  logic signed [W-1:0] hi_thr_i,
  input  logic signed [W-1:0] lo_thr_i,
  input  logic [2:0]          stage_i,
  input  logic                clr_we_i,
  input  logic [7:0]          clr_mask_i,
  output logic [7:0]          status_o
);
  localparam int STICKY_POS [N_STICKY] = '{POS_OVF, POS_UPD};

  logic rst_sync_n;
  logic above_q, below_q;
  logic [N_STICKY-1:0] st_set, st_clr, st_q;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic unused_mask;
  stat_t stat_d;

  adc_thr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  adc_thr_cmp #(.W(W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(upd_i),
    .err_i(err_i), .hi_i(hi_thr_i), .lo_i(lo_thr_i),
    .above_o(above_q), .below_o(below_q)
  );

  assign st_set = {upd_i, ovf_i};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    assign st_clr[g] = clr_we_i & clr_mask_i[STICKY_POS[g]];
    adc_thr_sticky u_flag (
      .clk_i(clk_i), .rst_ni(rst_sync_n),
      .set_i(st_set[g]), .clr_i(st_clr[g]), .q_o(st_q[g])
    );
  end

  assign unused_mask = ^{clr_mask_i[6:5], clr_mask_i[3:0]};

  always_comb begin
    stage_d = stage_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) stage_q <= '0;
    else             stage_q <= stage_d;
  end

  always_comb begin
    stat_d = '0;
    stat_d[POS_OVF]   = st_q[0];
    stat_d[POS_ABOVE] = above_q;
    stat_d[POS_BELOW] = below_q;
    stat_d[POS_UPD]   = st_q[1];
    stat_d[STAGE_W-1:0] = stage_q;
  end

  assign status_o = stat_d;
endmodule

// File: rtl/adc_thr_status_chk.sv
module adc_thr_status_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd,
  input logic signed [W-1:0] err,
  input logic signed [W-1:0] hi,
  input logic signed [W-1:0] lo,
  input logic                ovf,
  input logic [2:0]          stage,
  input logic                clr_we,
  input logic [7:0]          clr_mask,
  input logic [7:0]          status
);
  // R2
  above_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> status[6] == $past(err > hi));
  // R3
  below_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> status[5] == $past(err < lo));
  // R4
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(status[6:5]));
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> status[7]);
  // R5
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !(clr_we && clr_mask[7])) |=> status[7]);
  // R6
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> status[4]);
  // R6
  upd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[4] && !upd) |=> !status[4]);
  // R7
  ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && clr_we && clr_mask[7]) |=> status[7]);
  // R8
  stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status[2:0] == $past(stage));
  // R9
  ovf_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !clr_mask[7] && !ovf) |=> status[7] == $past(status[7]));
endmodule

bind adc_thr_status adc_thr_status_chk #(.W(W)) u_chk (
  .clk(clk_i), .rst_n(rst_sync_n), .upd(upd_i), .err(err_i),
  .hi(hi_thr_i), .lo(lo_thr_i), .ovf(ovf_i), .stage(stage_i),
  .clr_we(clr_we_i), .clr_mask(clr_mask_i), .status(status_o)
);

// File: tb/tb_adc_thr_status.sv
module tb_adc_thr_status;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic upd, ovf, clr_we;
  logic signed [W-1:0] err, hi, lo;
  logic [2:0] stage;
  logic [7:0] clr_mask;
  logic [7:0] status;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  adc_thr_status #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .err_i(err), .ovf_i(ovf),
    .hi_thr_i(hi), .lo_thr_i(lo), .stage_i(stage), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .status_o(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic signed [W-1:0] e);
    err = e; upd = 1'b1;
    step();
    upd = 1'b0;
  endtask

  task automatic wclr(input logic [7:0] m);
    clr_mask = m; clr_we = 1'b1;
    step();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; upd = 0; ovf = 0; clr_we = 0; clr_mask = 0;
    err = 0; hi = 0; lo = 0; stage = 0;
    repeat (3) step();
    chk("R1 during reset", status, 8'h00);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", status, 8'h00);
  endtask

  task automatic t_thresh();
    hi = 16'sd100; lo = -16'sd100;
    strobe(16'sd101);
    chk("R2 above", {7'b0, status[6]}, 8'd1);
    chk("R6 upd sets bit4", {7'b0, status[4]}, 8'd1);
    strobe(16'sd100);
    chk("R2 equal upper", {7'b0, status[6]}, 8'd0);
    strobe(-16'sd101);
    chk("R3 below", {6'b0, status[6:5]}, 8'b01);
    strobe(-16'sd100);
    chk("R3 equal lower", {7'b0, status[5]}, 8'd0);
  endtask

  task automatic t_hold();
    hi = 16'sd100; lo = -16'sd100;
    strobe(16'sd200);
    err = 16'sd0; step();
    chk("R4 err change", {6'b0, status[6:5]}, 8'b10);
    hi = 16'sd500; lo = 16'sd400; step();
    chk("R4 limit change", {6'b0, status[6:5]}, 8'b10);
  endtask

  task automatic t_signed();
    hi = -16'sd5; lo = -16'sd20;
    strobe(-16'sd3);
    chk("R10 neg above", {6'b0, status[6:5]}, 8'b10);
    strobe(-16'sd30);
    chk("R10 neg below", {6'b0, status[6:5]}, 8'b01);
    hi = -16'sd1; lo = -16'sd1;
    strobe(16'sh7FFF);
    chk("R10 max positive", {6'b0, status[6:5]}, 8'b10);
    strobe(16'sh8000);
    chk("R10 min negative", {6'b0, status[6:5]}, 8'b01);
  endtask

  task automatic t_ovf();
    wclr(8'h90);
    chk("R6 bit4 cleared", {7'b0, status[4]}, 8'd0);
    ovf = 1'b1; step(); ovf = 1'b0;
    chk("R5 ovf set", {7'b0, status[7]}, 8'd1);
    repeat (5) step();
    chk("R5 ovf sticky", {7'b0, status[7]}, 8'd1);
    wclr(8'h80);
    chk("R5 ovf cleared", {7'b0, status[7]}, 8'd0);
  endtask

  task automatic t_collide();
    ovf = 1'b1; clr_mask = 8'h80; clr_we = 1'b1;
    step();
    ovf = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R7 ovf set wins", {7'b0, status[7]}, 8'd1);
    err = 0; upd = 1'b1; clr_mask = 8'h10; clr_we = 1'b1;
    step();
    upd = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R7 upd set wins", {7'b0, status[4]}, 8'd1);
  endtask

  task automatic t_stage();
    stage = 3'd5;
    @(posedge clk); #1;
    chk("R8 stage one cycle late", {5'b0, status[2:0]}, 8'd5);
    @(negedge clk);
    stage = 3'd7; step();
    chk("R8 stage 7 bit3 zero", {4'b0, status[3:0]}, 8'd7);
  endtask

  task automatic t_ro();
    hi = 16'sd0; lo = -16'sd50;
    strobe(16'sd10);
    ovf = 1'b1; step(); ovf = 1'b0;
    stage = 3'd3; step();
    chk("R9 setup", status, 8'b1101_0011);
    wclr(8'h80);
    chk("R9 bit7 only cleared", status, 8'b0101_0011);
    wclr(8'h6F);
    chk("R9 ro bits untouched", status, 8'b0101_0011);
    wclr(8'hFF);
    chk("R9 full mask", status, 8'b0100_0011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_thresh();
    t_hold();
    t_signed();
    t_ovf();
    t_collide();
    t_stage();
    t_ro();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule